// File: doc/BRIEF.md
# Page Write Buffer Controller

This controller gathers the data bytes of one serial-memory write command into a page-wide latch. When the command ends, it hands the page to the nonvolatile array as a single commit. The bus front end reports four events: the start of a write command with its word address, each received data byte, the Stop condition, and the level of the write-protect input. The controller answers with a one-cycle commit request and a busy flag. The request carries the page number, a per-byte enable mask and the latched page data. The front end must withhold every acknowledge while the busy flag is high.

The byte pointer is split in two. The low bits give the offset within the page and advance once per byte. The high bits give the page number and are fixed for the whole command. A long burst therefore wraps inside its own page and overwrites earlier bytes. The write-protect level is read only in the cycle that carries Stop. After that the self-timed cycle runs for a fixed, parameterised number of clocks.

The state machine has four states: `ST_IDLE`, `ST_COLLECT`, `ST_COMMIT` and `ST_WRITING`.

- **open**: `ST_IDLE` goes to `ST_COLLECT` on a command start.
- **reopen**: `ST_COLLECT` stays in `ST_COLLECT` on a new command start, which discards the pending bytes.
- **store**: `ST_COLLECT` stays in `ST_COLLECT` on a data byte.
- **launch**: `ST_COLLECT` goes to `ST_COMMIT` on Stop, when at least one byte is latched and protection is low.
- **drop**: `ST_COLLECT` goes to `ST_IDLE` on Stop with no bytes latched or with protection high.
- **arm**: `ST_COMMIT` goes to `ST_WRITING` after one cycle.
- **finish**: `ST_WRITING` goes to `ST_IDLE` when the timer expires.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset `busy` and `commit_valid` are both low.
- R2: A byte received after a command start at address A is latched at page offset A[5:0], and offsets then follow in sequence. Bit i of `commit_mask` marks offset i, and `commit_data[8*i+7:8*i]` holds the byte at offset i. `commit_page` equals A[15:6].
- R3: Only the 6-bit offset advances. After offset 63 the next byte goes to offset 0 of the same page, and `commit_page` does not change.
- R4: When more than 64 bytes arrive before Stop, each byte beyond the 64th replaces the byte stored at its offset. The mask then shows all 64 bits set.
- R5: `commit_valid` is high for exactly one cycle, in the first cycle after the clock edge that samples Stop. In that cycle the page, mask and data are valid.
- R6: If `wp_level` is high in the Stop cycle, no commit occurs and `busy` stays low. A new command started in the next cycle is accepted and commits normally.
- R7: Raising `wp_level` after the Stop cycle has no effect on a commit already launched, and busy still lasts its full length.
- R8: `busy` is high for exactly BUSY_CYCLES consecutive cycles, beginning with the commit cycle, and is low afterwards.
- R9: While `busy` is high, command starts, bytes and Stop are ignored. The mask and data outputs stay unchanged and no further commit is issued.
- R10: Stop with no data byte since the command start launches no commit and leaves `busy` low.
- R11: A single data byte followed by Stop commits a mask with exactly one bit set.
- R12: A command start while bytes are pending discards them. Only bytes received after the newest start are committed, and at the newest address.
- R13: Bytes and Stop that arrive with no open command are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_begin | input | 1 | Write command start; loads the word address |
| wr_addr | input | ADDR_W | Starting word address of the command |
| byte_valid | input | 1 | One received data byte is present |
| byte_data | input | DATA_W | Received data byte |
| stop_seen | input | 1 | Stop condition ends the command |
| wp_level | input | 1 | Write-protect level; high blocks the commit |
| commit_valid | output | 1 | One-cycle commit request to the array |
| commit_page | output | ADDR_W-log2(PAGE_BYTES) | Page number of the commit |
| commit_mask | output | PAGE_BYTES | Byte enables, bit i for offset i |
| commit_data | output | PAGE_BYTES*DATA_W | Page data, byte i at bits 8i+7..8i |
| busy | output | 1 | Write cycle in progress; withhold acknowledges |

## Verification
Each event passes through a single register stage, so the commit request and the first busy cycle appear at the first falling-edge sample after the edge that took Stop. The bench reads them exactly there. A Stop that is dropped must show `busy` and `commit_valid` low at that same sample. Busy length is measured by counting falling-edge samples from the commit cycle until `busy` drops, and the count must equal BUSY_CYCLES. Stimulus sent during busy is driven inside that same counting loop, so the page outputs are compared in the cycles where a wrong design would change them.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_COMMIT,
        ST_WRITING
    } pgwr_state_e;
endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         wr_en,
    input  logic [OFS_W-1:0]             wr_ofs,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [PAGE_BYTES-1:0]        mask,
    output logic [PAGE_BYTES*DATA_W-1:0] data
);
    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask[i]                   <= 1'b0;
                data[i*DATA_W +: DATA_W] <= '0;
            end else if (clear) begin
                mask[i] <= 1'b0;
            end else if (wr_en && wr_ofs == OFS_W'(i)) begin
                mask[i]                   <= 1'b1;
                data[i*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    assert_lane_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear) |=> (mask[$past(wr_ofs)] &&
                               data[$past(wr_ofs)*DATA_W +: DATA_W] == $past(wr_data)));

    assert_clear_empties_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mask == '0));
endmodule

// File: rtl/pgwr_busy_timer.sv
module pgwr_busy_timer #(
    parameter int BUSY_CYCLES = 625000,
    localparam int CNT_W      = $clog2(BUSY_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 2);

    logic [CNT_W-1:0] cnt;
    logic             running;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= LOAD;
            running <= 1'b1;
        end else if (running) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
        end
    end

    assign done = running && (cnt == '0);

    assert_timer_descends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start && cnt != '0) |=> (running && cnt == $past(cnt) - 1'b1));

    assert_timer_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !running);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 64,
    parameter int BUSY_CYCLES = 625000
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_begin,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic                                  byte_valid,
    input  logic [DATA_W-1:0]                     byte_data,
    input  logic                                  stop_seen,
    input  logic                                  wp_level,
    output logic                                  commit_valid,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  commit_page,
    output logic [PAGE_BYTES-1:0]                 commit_mask,
    output logic [PAGE_BYTES*DATA_W-1:0]          commit_data,
    output logic                                  busy
);
    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    pgwr_state_e       state, state_nx;
    logic [OFS_W-1:0]  ofs_q;
    logic [PAGE_W-1:0] page_q;
    logic              accept_begin, accept_byte, timer_start, timer_done;

    assign accept_begin = wr_begin && (state == ST_IDLE || state == ST_COLLECT);
    assign accept_byte  = (state == ST_COLLECT) && byte_valid && !wr_begin && !stop_seen;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (wr_begin) state_nx = ST_COLLECT;
            ST_COLLECT: begin
                if (wr_begin)       state_nx = ST_COLLECT;
                else if (stop_seen) state_nx = (|commit_mask && !wp_level) ? ST_COMMIT : ST_IDLE;
            end
            ST_COMMIT:  state_nx = ST_WRITING;
            ST_WRITING: if (timer_done) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        commit_valid = 1'b0;
        busy         = 1'b0;
        timer_start  = 1'b0;
        unique case (state)
            ST_IDLE, ST_COLLECT: ;
            ST_COMMIT: begin
                commit_valid = 1'b1;
                busy         = 1'b1;
                timer_start  = 1'b1;
            end
            ST_WRITING: busy = 1'b1;
            default: ;
        endcase
    end

    // word pointer: page fixed per command, offset wraps within the page
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q  <= '0;
            page_q <= '0;
        end else if (accept_begin) begin
            ofs_q  <= wr_addr[OFS_W-1:0];
            page_q <= wr_addr[ADDR_W-1:OFS_W];
        end else if (accept_byte) begin
            ofs_q <= ofs_q + 1'b1;
        end
    end

    assign commit_page = page_q;

    pgwr_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept_begin),
        .wr_en   (accept_byte),
        .wr_ofs  (ofs_q),
        .wr_data (byte_data),
        .mask    (commit_mask),
        .data    (commit_data)
    );

    pgwr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (timer_start),
        .done  (timer_done)
    );

    assert_offset_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_byte && ofs_q == OFS_W'(PAGE_BYTES - 1)) |=> (ofs_q == '0 && $stable(page_q)));

    assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_byte |=> $stable(page_q));

    assert_commit_has_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> |commit_mask);

    assert_commit_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |=> (busy && !commit_valid));

    assert_protected_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COLLECT && stop_seen && !wr_begin && wp_level) |=> (!busy && !commit_valid));

    assert_page_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit_valid) |-> ($stable(commit_mask) && $stable(commit_data)));
endmodule

// File: tb/test_pgwr_ctrl.sv
module test_pgwr_ctrl;
    localparam int BUSY = 20;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_begin = 1'b0;
    logic [15:0]  wr_addr = '0;
    logic         byte_valid = 1'b0;
    logic [7:0]   byte_data = '0;
    logic         stop_seen = 1'b0;
    logic         wp_level = 1'b0;
    logic         commit_valid;
    logic [9:0]   commit_page;
    logic [63:0]  commit_mask;
    logic [511:0] commit_data;
    logic         busy;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pgwr_ctrl #(.BUSY_CYCLES(BUSY)) i_pgwr_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_begin(wr_begin), .wr_addr(wr_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_seen(stop_seen),
        .wp_level(wp_level), .commit_valid(commit_valid), .commit_page(commit_page),
        .commit_mask(commit_mask), .commit_data(commit_data), .busy(busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_byte(input string req, input int ofs, input logic [7:0] exp);
        chk(req, 64'(commit_data[ofs*8 +: 8]), 64'(exp));
    endtask

    task automatic do_begin(input logic [15:0] a);
        wr_begin = 1'b1; wr_addr = a;
        @(negedge clk);
        wr_begin = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic do_stop(input logic wp);
        wp_level = wp; stop_seen = 1'b1;
        @(negedge clk);
        stop_seen = 1'b0;
    endtask

    // counts busy samples from the current one; also counts extra commits
    task automatic run_busy(input string req, input bit junk);
        int cnt = 0;
        int extra = 0;
        while (busy && cnt < 10 * BUSY) begin
            cnt++;
            if (cnt > 1 && commit_valid) extra++;
            wr_begin = junk && cnt == 2; wr_addr = 16'hFFC0;
            byte_valid = junk && cnt == 3; byte_data = 8'hEE;
            stop_seen = junk && cnt == 4;
            @(negedge clk);
        end
        wr_begin = 1'b0; byte_valid = 1'b0; stop_seen = 1'b0;
        chk(req, 64'(cnt), 64'(BUSY));
        chk(req, 64'(extra), 64'd0);
    endtask

    task automatic t_reset;
        chk("R1", 64'(busy), 64'd0);
        chk("R1", 64'(commit_valid), 64'd0);
    endtask

    task automatic t_byte_write;
        do_begin(16'h1234);
        do_byte(8'h5A);
        do_stop(1'b0);
        chk("R5", 64'(commit_valid), 64'd1);
        chk("R2", 64'(commit_page), 64'h048);
        chk("R11", commit_mask, 64'd1 << 52);
        chk_byte("R2", 52, 8'h5A);
        run_busy("R8", 1'b0);
        chk("R8", 64'(busy), 64'd0);
        chk("R5", 64'(commit_valid), 64'd0);
    endtask

    task automatic t_wrap;
        do_begin(16'h12FE);
        for (int i = 0; i < 4; i++) do_byte(8'hA0 + 8'(i));
        do_stop(1'b0);
        chk("R3", 64'(commit_valid), 64'd1);
        chk("R3", 64'(commit_page), 64'h04B);
        chk("R3", commit_mask, (64'd3 << 62) | 64'd3);
        chk_byte("R3", 62, 8'hA0);
        chk_byte("R3", 63, 8'hA1);
        chk_byte("R3", 0, 8'hA2);
        chk_byte("R3", 1, 8'hA3);
        run_busy("R8", 1'b0);
    endtask

    task automatic t_overflow;
        logic [7:0] exp [64];
        do_begin(16'h0045);
        for (int i = 0; i < 66; i++) begin
            exp[(5 + i) % 64] = 8'(i);
            do_byte(8'(i));
        end
        do_stop(1'b0);
        chk("R4", 64'(commit_valid), 64'd1);
        chk("R4", commit_mask, '1);
        chk("R4", 64'(commit_page), 64'h001);
        for (int k = 0; k < 64; k++) chk_byte("R4", k, exp[k]);
        run_busy("R8", 1'b0);
    endtask

    task automatic t_protect;
        do_begin(16'h0300);
        do_byte(8'h11);
        do_stop(1'b1);
        chk("R6", 64'(commit_valid), 64'd0);
        chk("R6", 64'(busy), 64'd0);
        do_begin(16'h0080);
        do_byte(8'h77);
        do_stop(1'b0);
        chk("R6", 64'(commit_valid), 64'd1);
        chk("R6", commit_mask, 64'd1);
        chk_byte("R6", 0, 8'h77);
        run_busy("R6", 1'b0);
    endtask

    task automatic t_late_protect;
        do_begin(16'h0407);
        do_byte(8'h3C);
        do_stop(1'b0);
        wp_level = 1'b1;
        chk("R7", 64'(commit_valid), 64'd1);
        chk("R7", commit_mask, 64'd1 << 7);
        run_busy("R7", 1'b0);
        wp_level = 1'b0;
    endtask

    task automatic t_busy_ignore;
        logic [63:0]  m0;
        logic [511:0] d0;
        do_begin(16'h0510);
        do_byte(8'hC1);
        do_byte(8'hC2);
        do_stop(1'b0);
        m0 = commit_mask; d0 = commit_data;
        run_busy("R9", 1'b1);
        chk("R9", commit_mask, m0);
        checks++;
        if (commit_data !== d0) begin
            errors++;
            $display("FAIL R9: actual %0h expected %0h", commit_data, d0);
        end
        @(negedge clk);
        chk("R9", 64'(busy), 64'd0);
    endtask

    task automatic t_empty;
        do_begin(16'h0600);
        do_stop(1'b0);
        chk("R10", 64'(commit_valid), 64'd0);
        chk("R10", 64'(busy), 64'd0);
    endtask

    task automatic t_restart;
        do_begin(16'h0200);
        do_byte(8'h11);
        do_byte(8'h22);
        do_begin(16'h0210);
        do_byte(8'h33);
        do_stop(1'b0);
        chk("R12", 64'(commit_valid), 64'd1);
        chk("R12", 64'(commit_page), 64'h008);
        chk("R12", commit_mask, 64'd1 << 16);
        chk_byte("R12", 16, 8'h33);
        run_busy("R8", 1'b0);
    endtask

    task automatic t_idle_ignore;
        do_byte(8'h99);
        do_byte(8'h98);
        do_stop(1'b0);
        chk("R13", 64'(commit_valid), 64'd0);
        chk("R13", 64'(busy), 64'd0);
        do_begin(16'h0702);
        do_byte(8'h42);
        do_stop(1'b0);
        chk("R13", commit_mask, 64'd1 << 2);
        chk_byte("R13", 2, 8'h42);
        run_busy("R8", 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_write();
        t_wrap();
        t_overflow();
        t_protect();
        t_late_protect();
        t_busy_ignore();
        t_empty();
        t_restart();
        t_idle_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule